// File: doc/BRIEF.md
# Exception Entry and Status Controller

This block holds the status word of a small 32-bit core and performs the state changes that happen when the core takes an exception or returns from one. The status word holds four condition flags (N, Z, C, V), two interrupt-disable bits (I and F), an instruction-set state bit (T) and a 5-bit mode field. Five exception modes each own a saved copy of the status word. When the pipeline signals an instruction boundary and one or more exception requests are pending, the block picks one request. It switches the mode, raises the disable bits, copies the old status into the saved copy of the new mode, and produces the handler vector address and the link value. All of this completes in one clock.

A return strobe copies the saved status of the current mode back into the live status word. A status write port lets privileged code load the whole word. In user mode the same port can change only the condition flags. The block does not fetch, decode or run instructions. Its only outputs are the registered status, the saved status of the current mode, a one-cycle entry pulse, the vector address and the link value.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset the status word reads 0x000000D3 (mode 10011, I=1, F=1, T=0, flags 0). The entry pulse, vector and link read 0, and every saved status reads 0.
- R2: Requests are taken only when boundary_i is 1. When several eligible requests coincide, the winner follows this order, highest first: reset (req bit 0), data abort (bit 4), FIQ (bit 6), IRQ (bit 5), prefetch abort (bit 3), undefined instruction (bit 1), software interrupt (bit 2).
- R3: The vector is VEC_BASE plus 4 times the slot number: reset 0, undefined 1, software interrupt 2, prefetch abort 3, data abort 4, IRQ 6, FIQ 7. Slot 5 is never produced.
- R4: Entry sets the mode as follows: reset 10011, undefined 11011, software interrupt 10011, either abort 10111, IRQ 10010, FIQ 10001. Every entry sets I (bit 7) and clears T (bit 5). Reset and FIQ also set F (bit 6).
- R5: Entry leaves the flags (bits 31:28) and bits 27:8 unchanged.
- R6: On every entry except reset, the saved status of the target mode receives the status word as it was before the entry. Reset entry leaves all saved copies unchanged. spsr_o shows the saved copy of the current mode, or 0 in user (10000) and system (11111) mode.
- R7: take_o is 1 for exactly the one cycle after an accepted entry. link_o then holds next_pc_i as sampled at that entry.
- R8: An IRQ request is not eligible while I=1, and an FIQ request is not eligible while F=1.
- R9: With boundary_i at 0, requests have no effect on any output.
- R10: ret_i loads the status word from the saved copy of the current mode. In user or system mode, ret_i has no effect.
- R11: wr_en_i loads wr_data_i into the status word in any mode other than user. In user mode, only bits 31:28 are taken and the rest stay unchanged.
- R12: An accepted entry overrides ret_i and wr_en_i in the same cycle, and ret_i overrides wr_en_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| boundary_i | input | 1 | Instruction boundary strobe; requests are sampled only here |
| req_i | input | 7 | Exception requests: bit0 reset, 1 undefined, 2 software interrupt, 3 prefetch abort, 4 data abort, 5 IRQ, 6 FIQ |
| next_pc_i | input | ADDR_W | Address of the following instruction, captured as the link value |
| ret_i | input | 1 | Exception return strobe |
| wr_en_i | input | 1 | Status word write enable |
| wr_data_i | input | 32 | Status word write data |
| take_o | output | 1 | One-cycle pulse after an accepted entry |
| vec_o | output | ADDR_W | Handler vector address of the last entry |
| link_o | output | ADDR_W | Link value of the last entry |
| cpsr_o | output | 32 | Current status word |
| spsr_o | output | 32 | Saved status of the current mode |

## Verification
Every result is registered once. An entry, a return or a write applied before a rising edge shows on take_o, vec_o, link_o, cpsr_o and spsr_o in the cycle that follows that edge, and take_o falls again one edge later. The bench drives inputs on the falling edge and samples on the next falling edge. That way each check falls inside the single cycle in which its result is due, and take_o is checked low again in the next step. The bench sweeps every combination of the seven requests against all four I/F settings and predicts each step with its own model of the priority, mode and masking rules.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int NUM_REQ  = 7;
    localparam int NUM_BANK = 5;
    localparam int BANK_W   = $clog2(NUM_BANK);

    typedef enum logic [4:0] {
        MODE_USR = 5'b10000,
        MODE_FIQ = 5'b10001,
        MODE_IRQ = 5'b10010,
        MODE_SVC = 5'b10011,
        MODE_ABT = 5'b10111,
        MODE_UND = 5'b11011,
        MODE_SYS = 5'b11111
    } mode_e;

    // Encoding equals the vector slot number.
    typedef enum logic [2:0] {
        EXC_RST  = 3'd0,
        EXC_UND  = 3'd1,
        EXC_SWI  = 3'd2,
        EXC_PABT = 3'd3,
        EXC_DABT = 3'd4,
        EXC_IRQ  = 3'd6,
        EXC_FIQ  = 3'd7
    } exc_e;

    typedef struct packed {
        logic        n;
        logic        z;
        logic        c;
        logic        v;
        logic [19:0] rsvd;
        logic        i;
        logic        f;
        logic        t;
        logic [4:0]  mode;
    } psr_t;

    typedef struct packed {
        logic              hit;
        logic [BANK_W-1:0] idx;
    } bank_sel_t;

    function automatic bank_sel_t bank_of(input logic [4:0] mode);
        bank_sel_t s;
        s.hit = 1'b1;
        s.idx = '0;
        case (mode)
            MODE_FIQ: s.idx = BANK_W'(0);
            MODE_IRQ: s.idx = BANK_W'(1);
            MODE_SVC: s.idx = BANK_W'(2);
            MODE_ABT: s.idx = BANK_W'(3);
            MODE_UND: s.idx = BANK_W'(4);
            default:  s.hit = 1'b0;
        endcase
        return s;
    endfunction

    function automatic exc_e exc_of_bit(input int b);
        case (b)
            0:       return EXC_RST;
            1:       return EXC_UND;
            2:       return EXC_SWI;
            3:       return EXC_PABT;
            4:       return EXC_DABT;
            5:       return EXC_IRQ;
            default: return EXC_FIQ;
        endcase
    endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               boundary_i,
    input  logic [NUM_REQ-1:0] req_i,
    input  logic               irq_off_i,
    input  logic               fiq_off_i,
    output logic               take_o,
    output exc_e               kind_o,
    output logic [NUM_REQ-1:0] grant_o
);

    // Request bit indices, highest priority first.
    localparam int PRIO [NUM_REQ] = '{0, 4, 6, 5, 3, 1, 2};

    logic [NUM_REQ-1:0] eligible;
    int                 win;

    genvar g;
    generate
        for (g = 0; g < NUM_REQ; g++) begin : g_elig
            if (g == 5) begin : g_irq
                assign eligible[g] = boundary_i & req_i[g] & ~irq_off_i;
            end else if (g == 6) begin : g_fiq
                assign eligible[g] = boundary_i & req_i[g] & ~fiq_off_i;
            end else begin : g_plain
                assign eligible[g] = boundary_i & req_i[g];
            end
        end
    endgenerate

    always_comb begin
        win = -1;
        for (int r = NUM_REQ - 1; r >= 0; r--) begin
            if (eligible[PRIO[r]]) win = PRIO[r];
        end
        grant_o = '0;
        take_o  = (win >= 0);
        kind_o  = EXC_RST;
        if (win >= 0) begin
            grant_o[win] = 1'b1;
            kind_o       = exc_of_bit(win);
        end
    end

    assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o) && (take_o == (grant_o != '0)));

    assert_no_take_off_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary_i |-> !take_o);

    assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && kind_o == EXC_IRQ) |-> !irq_off_i);

    assert_fiq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && kind_o == EXC_FIQ) |-> !fiq_off_i);

endmodule

// File: rtl/exc_entry_calc.sv
module exc_entry_calc
    import exc_pkg::*;
#(
    parameter int              ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
    input  exc_e              kind_i,
    input  psr_t              old_i,
    output psr_t              new_o,
    output logic [ADDR_W-1:0] vec_o,
    output bank_sel_t         tgt_o
);

    localparam int SLOT_SHIFT = 2;

    always_comb begin
        new_o   = old_i;
        new_o.i = 1'b1;
        new_o.t = 1'b0;
        case (kind_i)
            EXC_RST:  begin new_o.mode = MODE_SVC; new_o.f = 1'b1; end
            EXC_UND:  new_o.mode = MODE_UND;
            EXC_SWI:  new_o.mode = MODE_SVC;
            EXC_PABT: new_o.mode = MODE_ABT;
            EXC_DABT: new_o.mode = MODE_ABT;
            EXC_IRQ:  new_o.mode = MODE_IRQ;
            default:  begin new_o.mode = MODE_FIQ; new_o.f = 1'b1; end
        endcase
        vec_o = VEC_BASE + (ADDR_W'(kind_i) << SLOT_SHIFT);
        tgt_o = bank_of(new_o.mode);
    end

endmodule

// File: rtl/spsr_bank.sv
module spsr_bank
    import exc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [BANK_W-1:0] widx_i,
    input  psr_t              wdata_i,
    input  bank_sel_t         rsel_i,
    output psr_t              rdata_o
);

    psr_t             bank_q [NUM_BANK];
    psr_t             bank_d [NUM_BANK];
    logic [NUM_BANK-1:0] hit;

    genvar g;
    generate
        for (g = 0; g < NUM_BANK; g++) begin : g_we
            assign hit[g] = we_i && (widx_i == BANK_W'(g));
        end
    endgenerate

    always_comb begin
        for (int k = 0; k < NUM_BANK; k++) begin
            bank_d[k] = hit[k] ? wdata_i : bank_q[k];
        end
        rdata_o = '0;
        for (int k = 0; k < NUM_BANK; k++) begin
            if (rsel_i.hit && rsel_i.idx == BANK_W'(k)) rdata_o = bank_q[k];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_BANK; k++) bank_q[k] <= '0;
        end else begin
            for (int k = 0; k < NUM_BANK; k++) bank_q[k] <= bank_d[k];
        end
    end

    assert_single_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit) && (we_i == (hit != '0)));

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter int                ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               boundary_i,
    input  logic [NUM_REQ-1:0] req_i,
    input  logic [ADDR_W-1:0]  next_pc_i,
    input  logic               ret_i,
    input  logic               wr_en_i,
    input  logic [31:0]        wr_data_i,
    output logic               take_o,
    output logic [ADDR_W-1:0]  vec_o,
    output logic [ADDR_W-1:0]  link_o,
    output logic [31:0]        cpsr_o,
    output logic [31:0]        spsr_o
);

    localparam psr_t RESET_PSR = '{n: 1'b0, z: 1'b0, c: 1'b0, v: 1'b0, rsvd: '0,
                                   i: 1'b1, f: 1'b1, t: 1'b0, mode: MODE_SVC};

    typedef struct packed {
        psr_t              cpsr;
        logic              take;
        exc_e              kind;
        logic [ADDR_W-1:0] vec;
        logic [ADDR_W-1:0] link;
    } state_t;

    state_t st_d, st_q;

    logic               arb_take;
    exc_e               arb_kind;
    logic [NUM_REQ-1:0] arb_grant;
    psr_t               entry_psr;
    logic [ADDR_W-1:0]  entry_vec;
    bank_sel_t          entry_tgt;
    bank_sel_t          cur_sel;
    psr_t               saved_psr;
    logic               bank_we;
    logic [BANK_W-1:0]  bank_widx;

    exc_arbiter u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .boundary_i (boundary_i),
        .req_i      (req_i),
        .irq_off_i  (st_q.cpsr.i),
        .fiq_off_i  (st_q.cpsr.f),
        .take_o     (arb_take),
        .kind_o     (arb_kind),
        .grant_o    (arb_grant)
    );

    exc_entry_calc #(.ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)) u_calc (
        .kind_i (arb_kind),
        .old_i  (st_q.cpsr),
        .new_o  (entry_psr),
        .vec_o  (entry_vec),
        .tgt_o  (entry_tgt)
    );

    assign cur_sel = bank_of(st_q.cpsr.mode);

    spsr_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (bank_we),
        .widx_i  (bank_widx),
        .wdata_i (st_q.cpsr),
        .rsel_i  (cur_sel),
        .rdata_o (saved_psr)
    );

    always_comb begin
        st_d      = st_q;
        st_d.take = 1'b0;
        bank_we   = 1'b0;
        bank_widx = entry_tgt.idx;
        if (arb_take) begin
            st_d.cpsr = entry_psr;
            st_d.take = 1'b1;
            st_d.kind = arb_kind;
            st_d.vec  = entry_vec;
            st_d.link = next_pc_i;
            bank_we   = (arb_kind != EXC_RST) && entry_tgt.hit;
        end else if (ret_i) begin
            if (cur_sel.hit) st_d.cpsr = saved_psr;
        end else if (wr_en_i) begin
            if (st_q.cpsr.mode == MODE_USR) begin
                st_d.cpsr.n = wr_data_i[31];
                st_d.cpsr.z = wr_data_i[30];
                st_d.cpsr.c = wr_data_i[29];
                st_d.cpsr.v = wr_data_i[28];
            end else begin
                st_d.cpsr = psr_t'(wr_data_i);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cpsr <= RESET_PSR;
            st_q.take <= 1'b0;
            st_q.kind <= EXC_RST;
            st_q.vec  <= '0;
            st_q.link <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign take_o = st_q.take;
    assign vec_o  = st_q.vec;
    assign link_o = st_q.link;
    assign cpsr_o = st_q.cpsr;
    assign spsr_o = saved_psr;

    assert_vec_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (vec_o[1:0] == 2'b00) && ((vec_o - VEC_BASE) != ADDR_W'(20))
                   && ((vec_o - VEC_BASE) < ADDR_W'(32)));

    assert_entry_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> cpsr_o[7] && !cpsr_o[5] && (cpsr_o[4:0] != MODE_USR) && (cpsr_o[4:0] != MODE_SYS));

    assert_flags_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (cpsr_o[31:8] == $past(cpsr_o[31:8])));

    assert_saved_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && st_q.kind != EXC_RST) |-> (spsr_o == $past(cpsr_o)));

    assert_take_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o || $past(arb_take));

    assert_user_guard_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !arb_take && !ret_i && cpsr_o[4:0] == MODE_USR)
        |=> (cpsr_o[27:0] == $past(cpsr_o[27:0])));

    assert_ret_user_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !arb_take && (cpsr_o[4:0] == MODE_USR || cpsr_o[4:0] == MODE_SYS))
        |=> $stable(cpsr_o));

endmodule

// File: tb/tb_exc_entry_ctrl.sv
module tb_exc_entry_ctrl;

    localparam int CLK_P  = 10;
    localparam int ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              boundary_i = 1'b0;
    logic [6:0]        req_i = '0;
    logic [ADDR_W-1:0] next_pc_i = '0;
    logic              ret_i = 1'b0;
    logic              wr_en_i = 1'b0;
    logic [31:0]       wr_data_i = '0;
    logic              take_o;
    logic [ADDR_W-1:0] vec_o, link_o;
    logic [31:0]       cpsr_o, spsr_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [31:0] m_cpsr;
    logic [31:0] m_spsr [5];

    always #(CLK_P/2) clk = ~clk;

    exc_entry_ctrl #(.ADDR_W(ADDR_W), .VEC_BASE('0)) dut (
        .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .req_i(req_i),
        .next_pc_i(next_pc_i), .ret_i(ret_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
        .take_o(take_o), .vec_o(vec_o), .link_o(link_o), .cpsr_o(cpsr_o), .spsr_o(spsr_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int bidx(input logic [4:0] m);
        case (m)
            5'b10001: return 0;
            5'b10010: return 1;
            5'b10011: return 2;
            5'b10111: return 3;
            5'b11011: return 4;
            default:  return -1;
        endcase
    endfunction

    function automatic logic [31:0] m_saved();
        int b = bidx(m_cpsr[4:0]);
        return (b >= 0) ? m_spsr[b] : 32'h0;
    endfunction

    // One clock step: drive, predict, sample one cycle later on the falling edge.
    task automatic step(input logic bnd, input logic [6:0] rq, input logic [31:0] pc,
                        input logic rt, input logic we, input logic [31:0] wd, input string tag);
        int order [7] = '{0, 4, 6, 5, 3, 1, 2};
        int slot  [7] = '{0, 1, 2, 3, 4, 6, 7};
        logic [4:0] mode [7] = '{5'b10011, 5'b11011, 5'b10011, 5'b10111, 5'b10111, 5'b10010, 5'b10001};
        int win = -1;
        logic [31:0] old = m_cpsr;
        boundary_i = bnd; req_i = rq; next_pc_i = pc; ret_i = rt; wr_en_i = we; wr_data_i = wd;
        if (bnd) begin
            for (int r = 6; r >= 0; r--) begin
                int b = order[r];
                bit ok = rq[b];
                if (b == 5 && old[7]) ok = 1'b0;
                if (b == 6 && old[6]) ok = 1'b0;
                if (ok) win = b;
            end
        end
        if (win >= 0) begin
            m_cpsr[4:0] = mode[win];
            m_cpsr[7]   = 1'b1;
            m_cpsr[5]   = 1'b0;
            if (win == 0 || win == 6) m_cpsr[6] = 1'b1;
            if (win != 0) m_spsr[bidx(mode[win])] = old;
        end else if (rt) begin
            if (bidx(old[4:0]) >= 0) m_cpsr = m_spsr[bidx(old[4:0])];
        end else if (we) begin
            if (old[4:0] == 5'b10000) m_cpsr[31:28] = wd[31:28];
            else m_cpsr = wd;
        end
        @(posedge clk);
        @(negedge clk);
        chk(tag, 32'(take_o), 32'(win >= 0));
        chk(tag, cpsr_o, m_cpsr);
        chk((win > 0) ? "R6" : tag, spsr_o, m_saved());
        if (win >= 0) begin
            chk("R5", {cpsr_o[31:8], 8'h0}, {old[31:8], 8'h0});
            chk((rq & (rq - 7'd1)) != 0 ? "R2" : "R3", vec_o, 32'(slot[win] * 4));
            chk("R7", link_o, pc);
        end
        boundary_i = 0; req_i = '0; ret_i = 0; wr_en_i = 0;
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        m_cpsr = 32'h0000_00D3;
        for (int k = 0; k < 5; k++) m_spsr[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", cpsr_o, 32'h0000_00D3);
        chk("R1", 32'(take_o), 32'h0);
        chk("R1", vec_o, 32'h0);
        chk("R1", link_o, 32'h0);
        chk("R1", spsr_o, 32'h0);

        // R9: requests without boundary
        step(1'b0, 7'h7F, 32'h1234, 1'b0, 1'b0, 32'h0, "R9");

        for (int f = 0; f < 4; f++) begin
            for (int rq = 1; rq < 128; rq++) begin
                logic [31:0] wd;
                logic [31:0] pc = 32'h0010_0000 + 32'(rq * 8 + f);
                string tg;
                wd = {4'(rq), 20'(rq * 37 + f), f[1], f[0], 1'b1, 5'b10000};
                step(1'b1, 7'h01, pc, 1'b0, 1'b0, 32'h0, "R4");
                step(1'b0, 7'h00, 32'h0, 1'b0, 1'b1, wd, "R11");
                step(1'b0, 7'h00, 32'h0, 1'b0, 1'b1, ~wd, "R11");
                if ((rq & (rq - 1)) != 0) tg = "R2";
                else if ((rq == 32 && f[1]) || (rq == 64 && f[0])) tg = "R8";
                else tg = "R4";
                step(1'b1, 7'(rq), pc, 1'b0, 1'b0, 32'h0, tg);
                step(1'b0, 7'h00, 32'h0, 1'b1, 1'b0, 32'h0, "R10");
                // R7: pulse drops on the next cycle
                step(1'b0, 7'h00, 32'h0, 1'b0, 1'b0, 32'h0, "R7");
            end
        end

        // R12: entry beats return and write; return beats write
        step(1'b1, 7'h01, 32'h40, 1'b0, 1'b0, 32'h0, "R4");
        step(1'b1, 7'h04, 32'h44, 1'b1, 1'b1, 32'hFFFF_FFFF, "R12");
        step(1'b0, 7'h00, 32'h0, 1'b1, 1'b1, 32'h0000_001F, "R12");
        // R10: return in system and user mode does nothing
        step(1'b0, 7'h00, 32'h0, 1'b0, 1'b1, 32'hA000_001F, "R11");
        step(1'b0, 7'h00, 32'h0, 1'b1, 1'b0, 32'h0, "R10");
        step(1'b0, 7'h00, 32'h0, 1'b0, 1'b1, 32'h5000_0010, "R11");
        step(1'b0, 7'h00, 32'h0, 1'b1, 1'b0, 32'h0, "R10");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule